// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block owns a small shared word memory and serves several requesters that compete for it. Each requester presents a request made of a valid bit, an opcode, an address and write data. A round-robin arbiter takes at most one request per cycle. The granted operation reads the addressed word and, where the opcode calls for it, writes the new value in the same cycle. No other access can fall between the read and the write of a read-modify-write.

The unit supports:
- plain load and plain store
- exchange
- test-and-set, for lock words where 0 is free and 1 is held
- fetch-and-increment
- a load-linked / store-conditional pair

Each requester has one link reservation. A store-conditional commits only while that reservation still covers the same address. Any successful write to that address by another requester breaks the reservation.

A registered response appears one cycle after acceptance. It carries the requester ID, the read data and a success flag. Responses come out in the order the requests were accepted.

Top module: `atomic_mem_unit`

## Requirements
- R1: At most one requester sees `req_ready` high in a cycle. `req_ready` is high only for a requester whose `req_valid` is high. A request is accepted when both are high.
- R2: Arbitration is round-robin. After requester i is accepted, the search for the next grant starts at requester i+1 and wraps around. After reset the search starts at requester 0.
- R3: Every accepted request produces exactly one response, with `rsp_valid` high in the cycle after acceptance. `rsp_id` is the accepted requester. No response appears without an acceptance.
- R4: Opcode 0 (load) and opcode 7 (reserved) return the word's value and leave memory unchanged. Opcode 1 (store) writes the write data and returns the previous value. `rsp_ok` is 1 for every opcode except store-conditional.
- R5: Opcode 2 (exchange) writes the write data and returns the previous value.
- R6: Opcode 3 (test-and-set) writes 1 and returns the previous value.
- R7: Opcode 4 (fetch-and-increment) returns the previous value and stores that value plus one, wrapping modulo 2^DATA_W.
- R8: Opcode 5 (load-linked) returns the word's value. It records a link for the requester on that address, replacing any earlier link of that requester.
- R9: Opcode 6 (store-conditional) succeeds only when the requester holds a link on that exact address. On success it writes the write data, returns read data 1 and `rsp_ok` 1, and consumes the link.
- R10: A store-conditional that fails returns read data 0 and `rsp_ok` 0 and leaves memory unchanged. It fails when there is no link or when the link is on a different address. It consumes the requester's link either way.
- R11: A memory write to an address clears the links that other requesters hold on that address. A write is a store, exchange, test-and-set, fetch-and-increment or successful store-conditional. The writer's own link and links on other addresses stay.
- R12: After reset every word reads 0, no requester holds a link and no response is pending.
- R13: When several linked requesters issue store-conditionals to the same address in the same cycle, only the first one granted succeeds. The others fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_REQ | Per-requester request valid |
| req_ready | output | NUM_REQ | Per-requester grant (one-hot or zero) |
| req_op | input | NUM_REQ*3 | Per-requester opcode, requester r at bits [3r+2:3r] |
| req_addr | input | NUM_REQ*ADDR_W | Per-requester word address |
| req_wdata | input | NUM_REQ*DATA_W | Per-requester write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_id | output | max(1,clog2(NUM_REQ)) | Requester the response belongs to |
| rsp_rdata | output | DATA_W | Old word value, or 1/0 for store-conditional |
| rsp_ok | output | 1 | Store-conditional success; 1 for all other opcodes |

## Verification
The interesting collision is a link being broken and a store-conditional asking for it. Both are decided by arbitration order inside a single grant sequence. The bench provokes this in three ways:
- several requesters link the same word;
- a plain write from a third requester is slipped in between link and store-conditional;
- all linked requesters raise store-conditionals in the same cycle.

A behavioural reference model runs alongside the design. It replays the round-robin order and the link table with plain arrays and integers. Every grant and every response is compared with the model each cycle. A long stretch of randomly chosen opcodes on only four addresses then forces conflicts at random.

// File: rtl/amu_pkg.sv
package amu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_XCHG  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSVD  = 3'd7
  } amu_op_e;
endpackage

// File: rtl/amu_rr_arbiter.sv
module amu_rr_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] gnt,
  output logic [IW-1:0]      gnt_idx,
  output logic               any
);
  logic [IW-1:0] ptr_q, ptr_d;

  // first requesting index at or after the pointer, wrapping
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int o = 0; o < NUM_REQ; o++) begin
      int idx;
      idx = (int'(ptr_q) + o) % NUM_REQ;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (any) begin
      if (gnt_idx == IW'(NUM_REQ - 1)) ptr_d = '0;
      else                             ptr_d = gnt_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (any) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/amu_link_table.sv
module amu_link_table
  import amu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [IW-1:0]     acc_id,
  input  amu_op_e           acc_op,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_en,
  output logic              link_hit
);
  logic [NUM_REQ-1:0] lv_q, lv_d;
  logic [ADDR_W-1:0]  la_q [NUM_REQ];
  logic [ADDR_W-1:0]  la_d [NUM_REQ];

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_link
    logic own;
    assign own = acc && (acc_id == IW'(r));

    always_comb begin
      lv_d[r] = lv_q[r];
      la_d[r] = la_q[r];
      if (own && acc_op == OP_LL) begin
        lv_d[r] = 1'b1;
        la_d[r] = acc_addr;
      end else if (own && acc_op == OP_SC) begin
        lv_d[r] = 1'b0;
      end else if (wr_en && !own && la_q[r] == acc_addr) begin
        lv_d[r] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lv_q[r] <= 1'b0;
        la_q[r] <= '0;
      end else if (acc) begin
        lv_q[r] <= lv_d[r];
        la_q[r] <= la_d[r];
      end
    end
  end

  assign link_hit = lv_q[acc_id] && (la_q[acc_id] == acc_addr);
endmodule

// File: rtl/amu_word_store.sv
module amu_word_store
  import amu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  amu_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              link_hit,
  output logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  output logic              ok
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] old_val, new_val;
  logic              wr;

  assign old_val = mem_q[addr];

  // read and write of one word resolve in the same cycle
  always_comb begin
    wr      = 1'b0;
    new_val = wdata;
    rdata   = old_val;
    ok      = 1'b1;
    unique case (op)
      OP_STORE, OP_XCHG: wr = 1'b1;
      OP_TAS: begin
        wr      = 1'b1;
        new_val = DATA_W'(1);
      end
      OP_FINC: begin
        wr      = 1'b1;
        new_val = old_val + 1'b1;
      end
      OP_SC: begin
        wr    = link_hit;
        ok    = link_hit;
        rdata = DATA_W'(link_hit);
      end
      default: ;
    endcase
  end

  assign wr_en = acc && wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= new_val;
    end
  end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_valid,
  output logic [NUM_REQ-1:0]        req_ready,
  input  logic [NUM_REQ*3-1:0]      req_op,
  input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
  input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
  output logic                      rsp_valid,
  output logic [IW-1:0]             rsp_id,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_ok
);
  logic              acc, wr_en, link_hit, ok_c;
  logic [IW-1:0]     acc_id;
  amu_op_e           acc_op;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, rdata_c;

  amu_rr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(req_ready), .gnt_idx(acc_id), .any(acc)
  );

  assign acc_op    = amu_op_e'(req_op[acc_id*3 +: 3]);
  assign acc_addr  = req_addr[acc_id*ADDR_W +: ADDR_W];
  assign acc_wdata = req_wdata[acc_id*DATA_W +: DATA_W];

  amu_link_table #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_links (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_id(acc_id), .acc_op(acc_op),
    .acc_addr(acc_addr), .wr_en(wr_en), .link_hit(link_hit)
  );

  amu_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(acc_op), .addr(acc_addr),
    .wdata(acc_wdata), .link_hit(link_hit), .wr_en(wr_en),
    .rdata(rdata_c), .ok(ok_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_id    <= '0;
      rsp_rdata <= '0;
      rsp_ok    <= 1'b0;
    end else if (acc) begin
      rsp_id    <= acc_id;
      rsp_rdata <= rdata_c;
      rsp_ok    <= ok_c;
    end
  end
endmodule

// File: rtl/amu_checker.sv
module amu_checker
  import amu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_REQ-1:0]   req_valid,
  input logic [NUM_REQ-1:0]   req_ready,
  input logic [NUM_REQ*3-1:0] req_op,
  input logic                 rsp_valid,
  input logic [IW-1:0]        rsp_id,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic                 rsp_ok
);
  logic          took;
  logic [IW-1:0] took_id;
  logic [2:0]    took_op;

  always_comb begin
    took_id = '0;
    took_op = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (req_ready[r]) begin
        took_id = IW'(r);
        took_op = req_op[r*3 +: 3];
      end
    end
  end
  assign took = |(req_ready & req_valid);

  assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  assert_grant_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> rsp_valid);
  assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> !rsp_valid);
  assert_rsp_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> rsp_id == $past(took_id));
  assert_sc_fail_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> rsp_rdata == '0);
  assert_ok_outside_sc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (took && took_op != 3'(OP_SC)) |=> rsp_ok);

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_rr
    assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[i] && req_valid[i]) |=>
        (!req_valid[(i+1) % NUM_REQ] || req_ready[(i+1) % NUM_REQ]));
  end
endmodule

bind atomic_mem_unit amu_checker #(
  .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_amu_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
  .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
);

// File: tb/test_atomic_mem_unit.sv
module test_atomic_mem_unit;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [N-1:0]    v;
  logic [2:0]      op [N];
  logic [AW-1:0]   ad [N];
  logic [DW-1:0]   wd [N];
  logic [N-1:0]    req_ready;
  logic [N*3-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic            rsp_valid, rsp_ok;
  logic [IW-1:0]   rsp_id;
  logic [DW-1:0]   rsp_rdata;

  always_comb begin
    for (int r = 0; r < N; r++) begin
      req_op[r*3 +: 3]     = op[r];
      req_addr[r*AW +: AW] = ad[r];
      req_wdata[r*DW +: DW] = wd[r];
    end
  end

  atomic_mem_unit #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) i_atomic_mem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mem_m [DEPTH];
  bit lv [N];
  int la [N];
  int ptr_m;

  task automatic chk(bit good, string req, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag(int o);
    case (o)
      0: return "R4 load";
      1: return "R4 store";
      2: return "R5 exchange";
      3: return "R6 test-and-set";
      4: return "R7 fetch-increment";
      5: return "R8 load-linked";
      6: return "R9 R10 R11 R13 store-conditional";
      default: return "R4 reserved";
    endcase
  endfunction

  // one cycle: predict grant and response, compare both
  task automatic step();
    int g = -1;
    int ev_rd = 0;
    bit ev_ok = 1;
    int o, a, old;
    bit wr = 0;
    bit hit;
    logic [N-1:0] exp_rdy = '0;
    for (int k = 0; k < N; k++) begin
      int idx = (ptr_m + k) % N;
      if (g < 0 && v[idx]) g = idx;
    end
    if (g >= 0) exp_rdy[g] = 1'b1;
    #1;
    chk(req_ready == exp_rdy, "R1 R2 grant", int'(req_ready), int'(exp_rdy));
    if (g >= 0) begin
      o = int'(op[g]);
      a = int'(ad[g]);
      old = mem_m[a];
      ev_rd = old;
      case (o)
        1, 2: begin wr = 1; mem_m[a] = int'(wd[g]); end
        3:    begin wr = 1; mem_m[a] = 1; end
        4:    begin wr = 1; mem_m[a] = (old + 1) & 16'hFFFF; end
        5:    begin lv[g] = 1; la[g] = a; end
        6: begin
          hit = lv[g] && la[g] == a;
          lv[g] = 0;
          ev_ok = hit;
          ev_rd = hit ? 1 : 0;
          if (hit) begin wr = 1; mem_m[a] = int'(wd[g]); end
        end
        default: ;
      endcase
      if (wr)
        for (int r = 0; r < N; r++)
          if (r != g && lv[r] && la[r] == a) lv[r] = 0;
      ptr_m = (g + 1) % N;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == (g >= 0), "R3 rsp_valid", int'(rsp_valid), int'(g >= 0));
    if (g >= 0) begin
      chk(int'(rsp_id) == g, "R3 rsp_id", int'(rsp_id), g);
      chk(int'(rsp_rdata) == ev_rd, tag(o), int'(rsp_rdata), ev_rd);
      chk(rsp_ok == ev_ok, tag(o), int'(rsp_ok), int'(ev_ok));
      v[g] = 1'b0;
    end
  endtask

  task automatic put(int r, int o, int a, int d);
    v[r]  = 1'b1;
    op[r] = 3'(o);
    ad[r] = AW'(a);
    wd[r] = DW'(d);
  endtask

  task automatic drain();
    while (v != '0) step();
  endtask

  task automatic one(int r, int o, int a, int d);
    put(r, o, a, d);
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    v = '0;
    for (int r = 0; r < N; r++) begin op[r] = '0; ad[r] = '0; wd[r] = '0; end
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 0;
    for (int r = 0; r < N; r++) begin lv[r] = 0; la[r] = 0; end
    ptr_m = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 no response in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 idle after reset", int'(rsp_valid), 0);

    // R12: memory reads zero, no links
    one(2, 0, 7, 0);
    one(1, 6, 7, 16'h5555);
    one(3, 0, 7, 0);

    // R4 R5 R6 R7 basic function
    one(0, 1, 3, 16'h1234);
    one(0, 0, 3, 0);
    one(0, 2, 3, 16'hAAAA);
    one(0, 7, 3, 16'h9999);
    one(0, 3, 5, 0);
    one(0, 3, 5, 0);
    one(0, 1, 6, 16'hFFFF);
    one(0, 4, 6, 0);
    one(0, 4, 6, 0);
    one(0, 0, 6, 0);

    // R8 R9 R10 link pair
    one(1, 5, 8, 0);
    one(1, 6, 8, 16'h0077);
    one(1, 0, 8, 0);
    one(1, 6, 8, 16'h0088);
    one(1, 5, 8, 0);
    one(1, 6, 9, 16'h0099);
    one(1, 0, 9, 0);

    // R11 intervening writes
    one(1, 5, 8, 0);
    one(2, 5, 8, 0);
    one(3, 5, 9, 0);
    one(0, 1, 8, 16'h0101);
    one(1, 6, 8, 16'h0202);
    one(2, 6, 8, 16'h0303);
    one(3, 6, 9, 16'h0404);
    one(1, 5, 10, 0);
    one(1, 1, 10, 16'h0505);
    one(1, 6, 10, 16'h0606);

    // R13 and R2: all link, then all store-conditional in one cycle
    for (int r = 0; r < N; r++) put(r, 5, 12, 0);
    drain();
    for (int r = 0; r < N; r++) put(r, 6, 12, 16'h0C00 + r);
    drain();
    one(0, 0, 12, 0);

    // random mix on few addresses
    for (int c = 0; c < 3000; c++) begin
      for (int r = 0; r < N; r++)
        if (!v[r] && ($urandom % 3) != 0)
          put(r, int'($urandom % 8), int'($urandom % 4), int'($urandom % 65536));
      step();
    end
    v = '0;
    step();

    finish_run();
  end
endmodule